// File: doc/BRIEF.md
# Channel Event Sequencer

This block drives one output channel of a multi-channel waveform generator. A channel's waveform is split into consecutive events. Each event is described by a two-field descriptor held in a small metadata memory: how many samples the event draws, and how many output slots each sample occupies. Raising the slot count for an event lowers that event's effective sample rate, so the rate can change partway through a waveform without touching the sample stream itself.

A start pulse sets the sequencer going from descriptor address 0. It fetches a descriptor, then on every slot tick from the downstream serializer it either takes a new word from the show-ahead sample FIFO (first slot of a sample) or holds the current one (repeat slots). When an event's samples are used up it fetches the next descriptor. A descriptor whose sample count is zero ends the sequence. The block then reports done and keeps presenting the last sample. Several channels share the start pulse and the slot tick, so they stay slot-aligned while each one moves through its own events at its own pace.

Top module: `evseq_top`

## Requirements
- R1: After reset, dac_word is 0, busy, done and underrun are 0, and neither fifo_pop nor meta_rd is asserted.
- R2: A trig pulse while idle or done asserts meta_rd with meta_addr 0 in the following cycle, raises busy and clears done and underrun. The memory returns the descriptor one cycle after meta_rd.
- R3: Each sample of an event is presented for exactly rep slot ticks. fifo_pop is asserted only on the first of those ticks, and dac_word takes the popped word at that clock edge. A rep value of 0 behaves as 1.
- R4: An event with sample count n performs n sample slots, one for each of n FIFO words, and then fetches the descriptor at the next address.
- R5: A descriptor with sample count 0 ends the sequence: done goes to 1, busy goes to 0, and dac_word keeps the last sample.
- R6: If fifo_empty is high on the first slot of a sample, no pop occurs, underrun is set and stays set until the next accepted trig, and dac_word repeats the previous value. The slot still counts toward the event.
- R7: Slot ticks that arrive while idle, done, or during a descriptor fetch cause no pop and no change of dac_word.
- R8: A trig pulse while busy is ignored, and the sequence in progress continues unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trig | input | 1 | Start pulse, shared by all channels |
| slot_tick | input | 1 | One-cycle pulse per output slot from the serializer |
| meta_rd | output | 1 | Descriptor read request |
| meta_addr | output | ADDR_W (6) | Descriptor address |
| meta_cnt | input | CNT_W (16) | Sample count of the descriptor, valid the cycle after meta_rd |
| meta_rep | input | REP_W (8) | Slots per sample of the descriptor, valid the cycle after meta_rd |
| fifo_empty | input | 1 | Sample FIFO has no word |
| fifo_data | input | SAMP_W (20) | Head word of the show-ahead sample FIFO |
| fifo_pop | output | 1 | Consume the head word |
| dac_word | output | SAMP_W (20) | Sample presented to the serializer |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Terminating descriptor reached |
| underrun | output | 1 | Sticky: a sample was needed while the FIFO was empty |

## Verification
The bench runs a set of multi-event sequences that mix repetition counts of 0, 1 and larger. A design that popped on every slot, or that treated a zero count as 256 repeats, would run ahead of the reference pop count or fall behind it. After each sequence the bench also checks which descriptor address was fetched last, which catches off-by-one errors at event boundaries. Directed cases put a slot tick inside the fetch window and ticks after completion, where a leaky design pops or changes its word. They also cover an empty FIFO on a first slot, where a wrong design pops garbage or forgets the flag, and a re-trigger mid-sequence, where a wrong design would restart the sequence and never finish in time.

// File: rtl/evseq_pkg.sv
package evseq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REQ,
    ST_LATCH,
    ST_RUN,
    ST_DONE
  } seq_state_e;

  // Slots per sample actually used: zero is promoted to one.
  function automatic int unsigned eff_reps(input int unsigned rep);
    return (rep == 0) ? 1 : rep;
  endfunction

  // Index of the final element of a run of n (n >= 1).
  function automatic int unsigned last_of(input int unsigned n);
    return (n == 0) ? 0 : n - 1;
  endfunction

endpackage

// File: rtl/evseq_fetch.sv
module evseq_fetch
  import evseq_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trig,
  input  logic              desc_end,
  input  logic              ev_last,
  output logic              meta_rd,
  output logic [ADDR_W-1:0] meta_addr,
  output logic              load,
  output logic              running,
  output logic              busy,
  output logic              done,
  output logic              start
);

  seq_state_e        state_q, state_d;
  logic [ADDR_W-1:0] ptr_q;

  assign start = trig && (state_q == ST_IDLE || state_q == ST_DONE);

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE, ST_DONE: if (trig) state_d = ST_REQ;
      ST_REQ:           state_d = ST_LATCH;
      ST_LATCH:         state_d = desc_end ? ST_DONE : ST_RUN;
      ST_RUN:           if (ev_last) state_d = ST_REQ;
      default:          state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      ptr_q   <= '0;
    end else begin
      state_q <= state_d;
      if (start)        ptr_q <= '0;
      else if (ev_last) ptr_q <= ptr_q + ADDR_W'(1);
    end
  end

  assign meta_rd   = (state_q == ST_REQ);
  assign meta_addr = ptr_q;
  assign load      = (state_q == ST_LATCH) && !desc_end;
  assign running   = (state_q == ST_RUN);
  assign busy      = (state_q == ST_REQ) || (state_q == ST_LATCH) || running;
  assign done      = (state_q == ST_DONE);

  p_done_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done));
  p_done_entry_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(desc_end));
  p_read_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    meta_rd |=> !meta_rd);

endmodule

// File: rtl/evseq_pacer.sv
module evseq_pacer
  import evseq_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int REP_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] ld_cnt,
  input  logic [REP_W-1:0] ld_rep,
  input  logic             step,
  output logic             first_slot,
  output logic             ev_last
);

  logic [CNT_W-1:0] cnt_q, samp_idx_q;
  logic [REP_W-1:0] rep_q, rep_idx_q;
  logic             slot_last, samp_last;

  assign first_slot = (rep_idx_q == '0);
  assign slot_last  = (rep_idx_q == REP_W'(last_of(32'(rep_q))));
  assign samp_last  = (samp_idx_q == CNT_W'(last_of(32'(cnt_q))));
  assign ev_last    = step && slot_last && samp_last;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q      <= '0;
      rep_q      <= REP_W'(1);
      samp_idx_q <= '0;
      rep_idx_q  <= '0;
    end else if (load) begin
      cnt_q      <= ld_cnt;
      rep_q      <= REP_W'(eff_reps(32'(ld_rep)));
      samp_idx_q <= '0;
      rep_idx_q  <= '0;
    end else if (step) begin
      if (slot_last) begin
        rep_idx_q  <= '0;
        samp_idx_q <= samp_idx_q + CNT_W'(1);
      end else begin
        rep_idx_q  <= rep_idx_q + REP_W'(1);
      end
    end
  end

  p_rep_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rep_idx_q < rep_q);
  p_rep_nonzero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rep_q != '0);

endmodule

// File: rtl/evseq_hold.sv
module evseq_hold #(
  parameter int SAMP_W = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic              miss,
  input  logic              clr,
  input  logic [SAMP_W-1:0] data,
  output logic [SAMP_W-1:0] word,
  output logic              underrun
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      word     <= '0;
      underrun <= 1'b0;
    end else begin
      if (take) word <= data;
      if (clr)       underrun <= 1'b0;
      else if (miss) underrun <= 1'b1;
    end
  end

  p_word_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !take |=> $stable(word));
  p_underrun_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (underrun && !clr) |=> underrun);
  p_take_miss_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(take && miss));

endmodule

// File: rtl/evseq_top.sv
module evseq_top
  import evseq_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int CNT_W  = 16,
  parameter int REP_W  = 8,
  parameter int SAMP_W = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trig,
  input  logic              slot_tick,
  output logic              meta_rd,
  output logic [ADDR_W-1:0] meta_addr,
  input  logic [CNT_W-1:0]  meta_cnt,
  input  logic [REP_W-1:0]  meta_rep,
  input  logic              fifo_empty,
  input  logic [SAMP_W-1:0] fifo_data,
  output logic              fifo_pop,
  output logic [SAMP_W-1:0] dac_word,
  output logic              busy,
  output logic              done,
  output logic              underrun
);

  // Named internal events
  logic desc_end, ev_last, load, running, start;
  logic step, first_slot, want_pop, miss;

  assign desc_end = (meta_cnt == '0);
  assign step     = slot_tick && running;
  assign want_pop = step && first_slot;
  assign fifo_pop = want_pop && !fifo_empty;
  assign miss     = want_pop && fifo_empty;

  evseq_fetch #(.ADDR_W(ADDR_W)) u_fetch (
    .clk(clk), .rst_n(rst_n), .trig(trig), .desc_end(desc_end),
    .ev_last(ev_last), .meta_rd(meta_rd), .meta_addr(meta_addr),
    .load(load), .running(running), .busy(busy), .done(done),
    .start(start)
  );

  evseq_pacer #(.CNT_W(CNT_W), .REP_W(REP_W)) u_pacer (
    .clk(clk), .rst_n(rst_n), .load(load), .ld_cnt(meta_cnt),
    .ld_rep(meta_rep), .step(step), .first_slot(first_slot),
    .ev_last(ev_last)
  );

  evseq_hold #(.SAMP_W(SAMP_W)) u_hold (
    .clk(clk), .rst_n(rst_n), .take(fifo_pop), .miss(miss),
    .clr(start), .data(fifo_data), .word(dac_word), .underrun(underrun)
  );

  p_pop_guard_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_pop |-> !fifo_empty);
  p_pop_in_run_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_pop |-> (running && slot_tick));
  p_retrig_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (running && trig && !ev_last) |=> running);
  p_start_reads_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (meta_rd && meta_addr == '0));

endmodule

// File: tb/evseq_top_test.sv
`timescale 1ns/1ps
module evseq_top_test;

  localparam int ADDR_W = 6, CNT_W = 16, REP_W = 8, SAMP_W = 20;
  localparam int BASE = 32'h10000;
  localparam int NV = 5;
  // cnt0, rep0, cnt1, rep1, cnt2, rep2 (cnt 0 terminates early)
  localparam int VEC [NV][6] = '{
    '{2, 1, 3, 2, 1, 0},
    '{1, 4, 2, 0, 0, 0},
    '{3, 3, 0, 5, 0, 0},
    '{4, 0, 1, 1, 2, 3},
    '{1, 1, 1, 1, 1, 1}
  };

  logic clk = 0, rst_n = 0, trig = 0, slot_tick = 0, fifo_empty = 0;
  logic meta_rd, fifo_pop, busy, done, underrun;
  logic [ADDR_W-1:0] meta_addr;
  logic [CNT_W-1:0]  meta_cnt;
  logic [REP_W-1:0]  meta_rep;
  logic [SAMP_W-1:0] fifo_data, dac_word;

  int mc [64];
  int mr [64];
  int pops = 0;
  int last_addr = -1;
  int exp_pops = 0;
  int checks = 0, fails = 0;

  always #2.5 clk = ~clk;

  assign fifo_data = SAMP_W'(BASE + pops);

  always @(posedge clk) begin
    if (fifo_pop) pops <= pops + 1;
    if (meta_rd) begin
      meta_cnt  <= CNT_W'(mc[meta_addr]);
      meta_rep  <= REP_W'(mr[meta_addr]);
      last_addr <= int'(meta_addr);
    end
  end

  evseq_top #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .REP_W(REP_W), .SAMP_W(SAMP_W)) uut (
    .clk(clk), .rst_n(rst_n), .trig(trig), .slot_tick(slot_tick),
    .meta_rd(meta_rd), .meta_addr(meta_addr), .meta_cnt(meta_cnt),
    .meta_rep(meta_rep), .fifo_empty(fifo_empty), .fifo_data(fifo_data),
    .fifo_pop(fifo_pop), .dac_word(dac_word), .busy(busy), .done(done),
    .underrun(underrun)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic int exp_word();
    return (exp_pops == 0) ? 0 : BASE + exp_pops - 1;
  endfunction

  task automatic pulse_trig();
    @(negedge clk) trig = 1;
    @(negedge clk) trig = 0;
  endtask

  // One slot tick, then check at the next negedge, then idle two cycles.
  task automatic tick(input string tag, input bit expect_pop);
    @(negedge clk) slot_tick = 1;
    @(negedge clk) slot_tick = 0;
    if (expect_pop) exp_pops++;
    chk({tag, " pops"}, pops, exp_pops);
    chk({tag, " word"}, int'(dac_word), exp_word());
    repeat (2) @(negedge clk);
  endtask

  task automatic clear_mem();
    for (int i = 0; i < 64; i++) begin mc[i] = 0; mr[i] = 0; end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    clear_mem();
    meta_cnt = '0; meta_rep = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 word", int'(dac_word), 0);
    chk("R1 flags", {busy, done, underrun, fifo_pop, meta_rd}, 0);
    rst_n = 1;
    @(negedge clk);
    chk("R1 after release", {busy, done, underrun, fifo_pop, meta_rd}, 0);

    // Table walk: R3, R4, R5
    for (int v = 0; v < NV; v++) begin
      int nev;
      clear_mem();
      nev = 0;
      for (int e = 0; e < 3; e++) begin
        if (VEC[v][2*e] == 0) break;
        mc[e] = VEC[v][2*e]; mr[e] = VEC[v][2*e+1];
        nev++;
      end
      @(negedge clk) trig = 1;
      @(negedge clk) trig = 0;
      // R2: fetch of address 0 in the cycle after the trigger
      chk("R2 meta_rd", {meta_rd, busy, done}, 3'b110);
      chk("R2 addr", int'(meta_addr), 0);
      repeat (2) @(negedge clk);
      for (int e = 0; e < nev; e++) begin
        int reps;
        reps = (mr[e] == 0) ? 1 : mr[e];
        for (int s = 0; s < mc[e]; s++)
          for (int r = 0; r < reps; r++)
            tick("R3 R4 table", r == 0);
      end
      repeat (2) @(negedge clk);
      chk("R4 last fetched addr", last_addr, nev);
      chk("R5 done/busy", {done, busy}, 2'b10);
      chk("R5 word held", int'(dac_word), exp_word());
    end

    // R7: tick during fetch and after done
    clear_mem();
    mc[0] = 1; mr[0] = 1; mc[1] = 1; mr[1] = 2;
    @(negedge clk) trig = 1;
    @(negedge clk) begin trig = 0; slot_tick = 1; end
    @(negedge clk) slot_tick = 0;
    chk("R7 fetch tick pops", pops, exp_pops);
    chk("R7 fetch tick word", int'(dac_word), exp_word());
    @(negedge clk);
    tick("R7 seq", 1);
    tick("R7 seq", 1);
    tick("R7 seq", 0);
    repeat (2) @(negedge clk);
    chk("R7 done", int'(done), 1);
    tick("R7 tick after done", 0);

    // R8: retrigger while busy is ignored
    clear_mem();
    mc[0] = 3; mr[0] = 1;
    pulse_trig();
    repeat (2) @(negedge clk);
    tick("R8 seq", 1);
    pulse_trig();
    tick("R8 seq", 1);
    tick("R8 seq", 1);
    repeat (2) @(negedge clk);
    chk("R8 finished in place", {done, busy}, 2'b10);
    chk("R8 last addr", last_addr, 1);

    // R6: underrun on a first slot
    clear_mem();
    mc[0] = 2; mr[0] = 2;
    pulse_trig();
    chk("R2 underrun clear", int'(underrun), 0);
    repeat (2) @(negedge clk);
    fifo_empty = 1;
    tick("R6 empty first slot", 0);
    chk("R6 flag", int'(underrun), 1);
    fifo_empty = 0;
    tick("R6 repeat slot", 0);
    tick("R6 next sample", 1);
    tick("R6 repeat slot 2", 0);
    repeat (2) @(negedge clk);
    chk("R6 slot counted, done", int'(done), 1);
    chk("R6 sticky", int'(underrun), 1);
    pulse_trig();
    chk("R2 trig clears underrun", {underrun, done}, 0);
    repeat (2) @(negedge clk);
    tick("R6 resume", 1);
    tick("R6 resume", 0);
    tick("R6 resume", 1);
    tick("R6 resume", 0);

    // R5: first descriptor terminates immediately
    repeat (2) @(negedge clk);
    clear_mem();
    pulse_trig();
    repeat (2) @(negedge clk);
    chk("R5 empty sequence", {done, busy}, 2'b10);
    chk("R5 empty seq word", int'(dac_word), exp_word());
    chk("R5 empty seq pops", pops, exp_pops);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule